// File: doc/BRIEF.md
# PWM Time-Base Counter with Shadowed Compare Registers

This block is the timing core of one PWM channel pair. A counter advances on a clock-enable tick and runs against a programmable period. It can run in a sawtooth pattern (up-count) or a triangle pattern (up-down). Two compare values, A and B, are held in shadow and active pairs. All matching uses the active copy. The active copy is refreshed from the shadow once per carrier cycle, at the zero point or at the period point, as a control bit selects.

The block emits single-cycle strobes when the counter reaches zero and when it reaches the period. It also emits strobes for compare-A and compare-B matches, split into rising-slope and falling-slope versions. Downstream action logic turns these strobes into output edges. A write port with a 2-bit address loads the period, the two compare values and a 3-bit control word.

Top module: `pwm_tbase`

## Requirements
- R1: After asynchronous reset the state is as follows. The counter is 0 and the direction flag is up (dir_up_o=1). Every event strobe is low. The period, both compare values (shadow and active) and the control word are all 0.
- R2: The counter and the direction flag change only on clocks where tick_i=1. With tick_i=0 they hold.
- R3: With control bit 0 = 0 (up-count), the counter goes 0,1,…,P and then returns to 0. P is the active period. A full cycle takes P+1 ticks, and the direction flag stays up.
- R4: With control bit 0 = 1 (up-down), the counter climbs to P with the direction flag up. It then descends to 0 with the flag down, and then climbs again from 1. A period of 0 holds the counter at 0.
- R5: A write to address 0 goes to a period shadow. The active period takes that shadow value only at the next zero event, so a running cycle is never shortened.
- R6: Addresses 1 and 2 write the A and B shadow values. When control bit 2 = 0, each active compare takes its shadow value at a reload point. With control bit 1 = 0 the reload point is the zero event; with control bit 1 = 1 it is the period event. The match that falls on the reload count itself still uses the old active value.
- R7: With control bit 2 = 1, writes to addresses 1 and 2 reach the active compare on the next clock, and no reload from shadow happens.
- R8: A compare strobe fires when the new counter value equals the active compare value. It appears on the _up_o output if the counter got there while counting up, and on the _dn_o output otherwise.
- R9: Every strobe lasts one clock and shows in the clock after the tick that produced the counter value. The zero strobe and the period strobe never fire together: the period strobe requires a non-zero count.
- R10: When srst_i=1, the counter goes to 0 with the direction flag up and all strobes stay low on the next clock. Register writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous counter clear |
| tick_i | input | 1 | Counter clock enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 period, 1 compare A, 2 compare B, 3 control |
| wr_data_i | input | CNT_W | Write data; control uses bits [2:0] |
| cnt_o | output | CNT_W | Current counter value |
| dir_up_o | output | 1 | 1 while counting up |
| zero_o | output | 1 | Counter reached zero |
| prd_o | output | 1 | Counter reached period |
| cmpa_up_o | output | 1 | Compare A match while counting up |
| cmpa_dn_o | output | 1 | Compare A match while counting down |
| cmpb_up_o | output | 1 | Compare B match while counting up |
| cmpb_dn_o | output | 1 | Compare B match while counting down |
| prd_act_o | output | CNT_W | Active period |
| cmpa_act_o | output | CNT_W | Active compare A |
| cmpb_act_o | output | CNT_W | Active compare B |

## Verification
The bench builds the block with CNT_W=8 and uses periods of 0 to 10. A full carrier cycle therefore takes only a few ticks, and each run of random stimulus crosses hundreds of reload points in both modes. The small width lets compare values sit at 0, at P, at P+1 and beyond P, which covers the 0% and 100% duty edge cases. Period 0 and period 1 exercise the guard that keeps the zero and period strobes apart. Random control writes switch modes and reload points in the middle of a cycle, including writes that land on the same clock as a reload.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_PRD  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPB = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd3;
  localparam int CTRL_W     = 3;
  localparam int CTRL_UPDN  = 0;
  localparam int CTRL_LDPRD = 1;
  localparam int CTRL_SHOFF = 2;
  localparam int NUM_CMP    = 2;
endpackage

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             adv_i,
  input  logic             updn_i,
  input  logic             prd_wr_i,
  input  logic [CNT_W-1:0] prd_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_up_o,
  output logic [CNT_W-1:0] cnt_nx_o,
  output logic             dir_nx_o,
  output logic             zero_nx_o,
  output logic             prd_nx_o,
  output logic [CNT_W-1:0] prd_act_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q, prd_sh_q, prd_act_q, cnt_nx;
  logic             dir_q, dir_nx;

  always_comb begin
    cnt_nx = cnt_q;
    dir_nx = dir_q;
    if (prd_act_q == ZERO) begin
      cnt_nx = ZERO;
      dir_nx = 1'b1;
    end else if (!updn_i) begin
      cnt_nx = (cnt_q >= prd_act_q) ? ZERO : cnt_q + ONE;
      dir_nx = 1'b1;
    end else if (dir_q) begin
      if (cnt_q >= prd_act_q) begin
        cnt_nx = cnt_q - ONE;
        dir_nx = 1'b0;
      end else begin
        cnt_nx = cnt_q + ONE;
        dir_nx = 1'b1;
      end
    end else begin
      if (cnt_q == ZERO) begin
        cnt_nx = ONE;
        dir_nx = 1'b1;
      end else begin
        cnt_nx = cnt_q - ONE;
        dir_nx = 1'b0;
      end
    end
  end

  assign zero_nx_o = (cnt_nx == ZERO);
  assign prd_nx_o  = (cnt_nx == prd_act_q) && (cnt_nx != ZERO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      dir_q     <= 1'b1;
      prd_sh_q  <= '0;
      prd_act_q <= '0;
    end else begin
      if (prd_wr_i) prd_sh_q <= prd_wdata_i;
      if (srst_i) begin
        cnt_q <= '0;
        dir_q <= 1'b1;
      end else if (adv_i) begin
        cnt_q <= cnt_nx;
        dir_q <= dir_nx;
        if (zero_nx_o) prd_act_q <= prd_sh_q;  // period only switches at a zero boundary
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign dir_up_o  = dir_q;
  assign cnt_nx_o  = cnt_nx;
  assign dir_nx_o  = dir_nx;
  assign prd_act_o = prd_act_q;
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             direct_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_nx_i,
  input  logic             dir_nx_i,
  output logic [CNT_W-1:0] act_o,
  output logic             up_o,
  output logic             dn_o
);
  logic [CNT_W-1:0] sh_q, act_q;
  logic             up_q, dn_q, hit;

  // match uses the active value before any reload at this edge
  assign hit = adv_i && (cnt_nx_i == act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      act_q <= '0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      if (wr_i) sh_q <= wdata_i;
      if (wr_i && direct_i) act_q <= wdata_i;
      else if (load_i)      act_q <= sh_q;
      up_q <= hit && dir_nx_i;
      dn_q <= hit && !dir_nx_i;
    end
  end

  assign act_o = act_q;
  assign up_o  = up_q;
  assign dn_o  = dn_q;
endmodule

// File: rtl/pwm_tbase.sv
module pwm_tbase
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dir_up_o,
  output logic              zero_o,
  output logic              prd_o,
  output logic              cmpa_up_o,
  output logic              cmpa_dn_o,
  output logic              cmpb_up_o,
  output logic              cmpb_dn_o,
  output logic [CNT_W-1:0]  prd_act_o,
  output logic [CNT_W-1:0]  cmpa_act_o,
  output logic [CNT_W-1:0]  cmpb_act_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              adv, zero_nx, prd_nx, dir_nx, cmp_load, zero_q, prd_q;
  logic [CNT_W-1:0]  cnt_nx;
  logic [CNT_W-1:0]  act   [NUM_CMP];
  logic              m_up  [NUM_CMP];
  logic              m_dn  [NUM_CMP];

  assign adv = tick_i && !srst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_CTRL) ctrl_q <= wr_data_i[CTRL_W-1:0];
  end

  pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .srst_i      (srst_i),
    .adv_i       (adv),
    .updn_i      (ctrl_q[CTRL_UPDN]),
    .prd_wr_i    (wr_en_i && wr_addr_i == ADDR_PRD),
    .prd_wdata_i (wr_data_i),
    .cnt_o       (cnt_o),
    .dir_up_o    (dir_up_o),
    .cnt_nx_o    (cnt_nx),
    .dir_nx_o    (dir_nx),
    .zero_nx_o   (zero_nx),
    .prd_nx_o    (prd_nx),
    .prd_act_o   (prd_act_o)
  );

  assign cmp_load = adv && !ctrl_q[CTRL_SHOFF] &&
                    (ctrl_q[CTRL_LDPRD] ? prd_nx : zero_nx);

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    localparam logic [ADDR_W-1:0] MY_ADDR = (gi == 0) ? ADDR_CMPA : ADDR_CMPB;
    pwm_cmp_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adv_i    (adv),
      .wr_i     (wr_en_i && wr_addr_i == MY_ADDR),
      .wdata_i  (wr_data_i),
      .direct_i (ctrl_q[CTRL_SHOFF]),
      .load_i   (cmp_load),
      .cnt_nx_i (cnt_nx),
      .dir_nx_i (dir_nx),
      .act_o    (act[gi]),
      .up_o     (m_up[gi]),
      .dn_o     (m_dn[gi])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_q <= 1'b0;
      prd_q  <= 1'b0;
    end else begin
      zero_q <= adv && zero_nx;
      prd_q  <= adv && prd_nx;
    end
  end

  assign zero_o     = zero_q;
  assign prd_o      = prd_q;
  assign cmpa_act_o = act[0];
  assign cmpb_act_o = act[1];
  assign cmpa_up_o  = m_up[0];
  assign cmpa_dn_o  = m_dn[0];
  assign cmpb_up_o  = m_up[1];
  assign cmpb_dn_o  = m_dn[1];
endmodule

// File: rtl/pwm_tbase_chk.sv
module pwm_tbase_chk
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              srst_i,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [CNT_W-1:0]  wr_data_i,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              dir_up_o,
  input logic              zero_o,
  input logic              prd_o,
  input logic              cmpa_up_o,
  input logic              cmpa_dn_o,
  input logic              cmpb_up_o,
  input logic              cmpb_dn_o,
  input logic [CNT_W-1:0]  prd_act_o,
  input logic [CNT_W-1:0]  cmpa_act_o,
  input logic [CNT_W-1:0]  cmpb_act_o
);
  a_r2_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !srst_i) |=> ($stable(cnt_o) && $stable(dir_up_o)));

  a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= prd_act_o);

  a_r7_direct_write_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_CMPA && ctrl_q[CTRL_SHOFF]) |=> cmpa_act_o == $past(wr_data_i));

  a_r7_direct_write_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_CMPB && ctrl_q[CTRL_SHOFF]) |=> cmpb_act_o == $past(wr_data_i));

  a_r8_up_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpa_up_o || cmpb_up_o) |-> dir_up_o);

  a_r8_dn_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpa_dn_o || cmpb_dn_o) |-> !dir_up_o);

  a_r9_zero_prd_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(zero_o && prd_o));

  a_r9_zero_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> cnt_o == '0);

  a_r10_srst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (cnt_o == '0 && dir_up_o && !zero_o && !prd_o &&
                !cmpa_up_o && !cmpa_dn_o && !cmpb_up_o && !cmpb_dn_o));
endmodule

bind pwm_tbase pwm_tbase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .srst_i     (srst_i),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .ctrl_q     (ctrl_q),
  .cnt_o      (cnt_o),
  .dir_up_o   (dir_up_o),
  .zero_o     (zero_o),
  .prd_o      (prd_o),
  .cmpa_up_o  (cmpa_up_o),
  .cmpa_dn_o  (cmpa_dn_o),
  .cmpb_up_o  (cmpb_up_o),
  .cmpb_dn_o  (cmpb_dn_o),
  .prd_act_o  (prd_act_o),
  .cmpa_act_o (cmpa_act_o),
  .cmpb_act_o (cmpb_act_o)
);

// File: tb/sim_pwm_tbase.sv
`timescale 1ns/1ps
module sim_pwm_tbase;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             srst = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [CNT_W-1:0] cnt, prd_act, cmpa_act, cmpb_act;
  logic             dir_up, zero, prd, ca_up, ca_dn, cb_up, cb_dn;

  always #10 clk = ~clk;  // 50 MHz

  pwm_tbase #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cnt_o(cnt), .dir_up_o(dir_up), .zero_o(zero), .prd_o(prd),
    .cmpa_up_o(ca_up), .cmpa_dn_o(ca_dn), .cmpb_up_o(cb_up), .cmpb_dn_o(cb_dn),
    .prd_act_o(prd_act), .cmpa_act_o(cmpa_act), .cmpb_act_o(cmpb_act)
  );

  int n_chk = 0, n_fail = 0;

  // reference model state
  int m_cnt = 0, m_dir = 1, m_pact = 0, m_psh = 0, m_ctrl = 0;
  int m_sh[2] = '{0, 0};
  int m_act[2] = '{0, 0};
  int e_zero = 0, e_prd = 0;
  int e_up[2] = '{0, 0};
  int e_dn[2] = '{0, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int nxt_cnt(input int c, input int d, input int p, input int updn, output int nd);
    if (p == 0) begin nd = 1; return 0; end
    if (!updn) begin nd = 1; return (c >= p) ? 0 : c + 1; end
    if (d) begin
      if (c >= p) begin nd = 0; return c - 1; end
      nd = 1; return c + 1;
    end
    if (c == 0) begin nd = 1; return 1; end
    nd = 0; return c - 1;
  endfunction

  task automatic compare_all();
    string rc;
    rc = (m_ctrl & 1) ? "R4" : "R3";
    chk(int'(cnt) == m_cnt, rc, int'(cnt), m_cnt);
    chk(int'(dir_up) == m_dir, rc, int'(dir_up), m_dir);
    chk(int'(zero) == e_zero, "R9 zero", int'(zero), e_zero);
    chk(int'(prd) == e_prd, "R9 prd", int'(prd), e_prd);
    chk(int'(ca_up) == e_up[0], "R8 a_up", int'(ca_up), e_up[0]);
    chk(int'(ca_dn) == e_dn[0], "R8 a_dn", int'(ca_dn), e_dn[0]);
    chk(int'(cb_up) == e_up[1], "R8 b_up", int'(cb_up), e_up[1]);
    chk(int'(cb_dn) == e_dn[1], "R8 b_dn", int'(cb_dn), e_dn[1]);
    chk(int'(prd_act) == m_pact, "R5", int'(prd_act), m_pact);
    chk(int'(cmpa_act) == m_act[0], "R6/R7 a", int'(cmpa_act), m_act[0]);
    chk(int'(cmpb_act) == m_act[1], "R6/R7 b", int'(cmpb_act), m_act[1]);
  endtask

  // one clock: drive now (just after a falling edge), model, then check at next falling edge
  task automatic step(input bit t, input bit s, input bit w, input int a, input int d);
    int nc, nd, shoff, ldprd;
    tick = t; srst = s; wr_en = w; wr_addr = a[1:0]; wr_data = d[CNT_W-1:0];
    shoff = (m_ctrl >> 2) & 1;
    ldprd = (m_ctrl >> 1) & 1;
    e_zero = 0; e_prd = 0;
    for (int k = 0; k < 2; k++) begin e_up[k] = 0; e_dn[k] = 0; end
    if (s) begin
      m_cnt = 0; m_dir = 1;
    end else if (t) begin
      nc = nxt_cnt(m_cnt, m_dir, m_pact, m_ctrl & 1, nd);
      e_zero = (nc == 0);
      e_prd  = (nc == m_pact) && (nc != 0);
      for (int k = 0; k < 2; k++) begin
        if (nc == m_act[k]) begin e_up[k] = nd; e_dn[k] = 1 - nd; end
      end
      for (int k = 0; k < 2; k++)
        if (!shoff && (ldprd ? e_prd : e_zero)) m_act[k] = m_sh[k];
      if (e_zero) m_pact = m_psh;
      m_cnt = nc; m_dir = nd;
    end
    if (w) begin
      case (a)
        0: m_psh = d;
        1, 2: begin
          m_sh[a-1] = d;
          if (shoff) m_act[a-1] = d;
        end
        default: m_ctrl = d & 7;
      endcase
    end
    @(negedge clk);
    compare_all();
    tick = 0; srst = 0; wr_en = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    summary();
    $finish;
  end

  initial begin
    int saved;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cnt == 0 && dir_up == 1, "R1 cnt/dir", int'(cnt), 0);
    chk(!zero && !prd && !ca_up && !ca_dn && !cb_up && !cb_dn, "R1 strobes", int'(zero), 0);
    chk(prd_act == 0 && cmpa_act == 0 && cmpb_act == 0, "R1 regs", int'(prd_act), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: up mode, period 4, compare A=2, B=5 (never reached), reload at zero
    step(0, 0, 1, 0, 4);
    step(0, 0, 1, 1, 2);
    step(0, 0, 1, 2, 5);
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0);
    chk(m_pact == 4, "R5 period active", m_pact, 4);

    // R2: no tick holds counter
    saved = int'(cnt);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0);
    chk(int'(cnt) == saved, "R2 hold", int'(cnt), saved);

    // R5: period change mid-cycle waits for zero
    step(1, 0, 1, 0, 7);
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0);

    // R4 + R6: up-down, reload on period
    step(0, 0, 1, 3, 3);
    step(0, 0, 1, 1, 0);
    step(0, 0, 1, 2, 7);
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 0);

    // R7: shadow off, direct writes
    step(0, 0, 1, 3, 5);
    step(1, 0, 1, 1, 3);
    chk(int'(cmpa_act) == 3, "R7 direct", int'(cmpa_act), 3);
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0);

    // R9: period 1 and period 0 boundaries
    step(1, 0, 1, 0, 1);
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0);
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0);
    chk(int'(cnt) == 0, "R9 period zero hold", int'(cnt), 0);

    // R10: sync reset
    step(1, 0, 1, 0, 6);
    for (int i = 0; i < 9; i++) step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    chk(cnt == 0 && dir_up == 1 && !zero && !prd, "R10 srst", int'(cnt), 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit t, s, w;
      int a, d;
      t = ($urandom_range(3, 0) != 0);
      s = ($urandom_range(199, 0) == 0);
      w = ($urandom_range(7, 0) == 0);
      a = $urandom_range(3, 0);
      case (a)
        0:       d = $urandom_range(10, 0);
        3:       d = $urandom_range(7, 0);
        default: d = $urandom_range(11, 0);
      endcase
      step(t, s, w, a, d);
    end

    summary();
    $finish;
  end
endmodule